// File: doc/BRIEF.md
# One-Wire Bit Slot Engine

This block is a bus master for a single open-drain one-wire line. Each command runs one time slot. A reset slot pulls the line low for a long time and then listens for a presence answer. A bit slot pulls the line low briefly to send a 1, or for most of the slot to send a 0, and then reads back what the line does. The master never samples the line at a single instant. It releases the line, stamps the first rising edge after the release with a tick count, and compares that stamp with a per-slot threshold. An early edge reads as 1. A late edge, where a device held the line low past the threshold, reads as 0.

Slot timing is counted in ticks of a prescaled clock; `TICK_DIV` system clocks make one tick. Every phase time is a parameter. There are two timing tables, and the `overdrive` input picks the shorter one. A watchdog ends a slot whose release edge never arrives and reports an error code that depends on the command. A block shifter on top runs up to `MAX_BITS` bit slots in a row, least-significant bit first. In read mode it sends 1s, and it abandons the block at the first failed slot.

Top module: `ow_slot_engine`

## Requirements
- R1: After reset, and whenever `busy` is low, `owDriveLow` is 0 (line released); after reset `busy`, `done` and `blkRdData` are 0.
- R2: A `start` or `blkStart` sampled while idle raises `busy` on the next clock. `done` is a one-cycle pulse, and `busy` falls on the same edge. A `start` or `blkStart` that arrives while busy has no effect. When both strobes arrive together while idle, `start` wins.
- R3: The low pulse lasts exactly `relTime*TICK_DIV+1` clocks. `relTime` is the reset low time for a reset, the short time for a bit slot writing 1, and the long time for a bit slot writing 0.
- R4: With `overdrive`=1 the slot uses the second, shorter set of low, sample and end times.
- R5: The first rising edge of the synchronized line after release is stamped in ticks, and edges while the master drives low are ignored. `result`=1 when the stamp is at or below the sample threshold, and 0 when it is later.
- R6: For a reset (`cmdReset`=1), `result`=0 means a device answered with presence and 1 means no device answered. `wrBit` has no effect on a reset.
- R7: A slot that sees its edge completes when the tick count reaches the slot end. `done` appears `endTime*TICK_DIV+2` clocks after the clock edge that sampled the start.
- R8: When no edge has been seen by `endTime+WDOG_EXTRA` ticks, the slot ends with `result`=0 and `err`=1 for a reset or `err`=2 for a bit slot. `done` appears `(endTime+WDOG_EXTRA)*TICK_DIV+2` clocks after the edge that sampled the start.
- R9: In a block write, slot i sends bit i of `blkWrData` (least significant bit first) and the block runs `blkLen` slots.
- R10: A block read clears `blkRdData` when the block starts and sends 1 in every slot. In every block, bit i of `blkRdData` is the value read in slot i, and bits at or above `blkLen` stay 0.
- R11: A failed slot inside a block ends the block at once with `err`=3 and `result`=0, and no further slot starts.
- R12: A command that completes normally reports `err`=0. A block with `blkLen`=0 completes 2 clocks after the edge that sampled the start, without driving the line, and reports `result`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Strobe: run one slot |
| cmdReset | input | 1 | 1 = reset/presence slot, 0 = bit slot |
| wrBit | input | 1 | Bit to send in a bit slot |
| overdrive | input | 1 | Selects the short timing table (slot or block) |
| blkStart | input | 1 | Strobe: run a block of bit slots |
| blkRead | input | 1 | Block mode: 1 = read (send 1s), 0 = write |
| blkLen | input | $clog2(MAX_BITS+1) | Number of bits in the block |
| blkWrData | input | MAX_BITS | Block write data, bit 0 sent first |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 1 | Bit read or presence result |
| err | output | 2 | 0 ok, 1 presence error, 2 data error, 3 block error |
| blkRdData | output | MAX_BITS | Bits read during the last block, bit i from slot i |
| owDriveLow | output | 1 | Open-drain enable: 1 pulls the line low |
| owIn | input | 1 | Line level as seen at the pin |

## Verification
Every result is tied to the clock edge that samples the strobe. A completed slot raises `done` `endTime*TICK_DIV+2` clocks later, a watchdog ending raises it `(endTime+WDOG_EXTRA)*TICK_DIV+2` clocks later, and an empty block raises it after 2 clocks. The low pulse is exactly `relTime*TICK_DIV+1` clocks long. The bench counts falling clock edges from the one on which it raises a strobe, compares that count with these figures exactly, and reads `result`, `err` and `blkRdData` on the same falling edge on which `done` is seen. A device model holds the line past the midpoint between the sample threshold and the slot end, so each read value is decided well away from the threshold.

// File: rtl/ow_pkg.sv
package ow_pkg;

  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_PRESENCE = 2'd1,
    ERR_DATA     = 2'd2,
    ERR_HW       = 2'd3
  } owErr_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_NEXT = 2'd2
  } owState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic slotGo;     // begin a slot: clear timers, pull line low
    logic slotRst;    // slot is a reset/presence slot
    logic slotWbit;   // bit to send when not taken from the block shifter
    logic slotUseTx;  // take the bit to send from the block shifter
    logic slotOd;     // use the short timing table
    logic blkLoad;    // load shifter, clear receive buffer
    logic blkRdMode;  // block read: fill transmit bits with ones
    logic blkShift;   // store read bit and advance the shifter
  } owStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic slotDone;     // edge seen and slot end reached
    logic slotTimeout;  // no edge by the watchdog limit
    logic bitVal;       // value decided from the captured edge
  } owStatus_t;

endpackage

// File: rtl/ow_datapath.sv
module ow_datapath
  import ow_pkg::*;
#(
  parameter int TICK_DIV   = 100,
  parameter int CNT_W      = 12,
  parameter int MAX_BITS   = 64,
  parameter int T_RST_LOW  = 960,
  parameter int T_RST_SMP  = 1100,
  parameter int T_RST_END  = 1920,
  parameter int T_B1_LOW   = 12,
  parameter int T_B0_LOW   = 120,
  parameter int T_B_SMP    = 30,
  parameter int T_B_END    = 140,
  parameter int O_RST_LOW  = 140,
  parameter int O_RST_SMP  = 157,
  parameter int O_RST_END  = 280,
  parameter int O_B1_LOW   = 2,
  parameter int O_B0_LOW   = 15,
  parameter int O_B_SMP    = 4,
  parameter int O_B_END    = 20,
  parameter int WDOG_EXTRA = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  owStrobe_t           ctl,
  input  logic                owIn,
  output logic                owDriveLow,
  input  logic [MAX_BITS-1:0] blkWrData,
  output logic [MAX_BITS-1:0] blkRdData,
  output owStatus_t           sts
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int IDX_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;

  logic [PRE_W-1:0]    preCnt;
  logic                tickEn;
  logic [CNT_W-1:0]    tickCnt;
  logic                busMeta, busSync, busPrev;
  logic                riseSeen;
  logic                rstReg, odReg, wbitReg;
  logic                driveLow;
  logic                edgeSeen;
  logic [CNT_W-1:0]    capTick;
  logic [CNT_W-1:0]    relT, smpT, endT, wdT;
  logic [MAX_BITS-1:0] txBuf, rxBuf;
  logic [IDX_W-1:0]    bitIdx;

  // tick prescaler and slot-relative tick counter
  assign tickEn = (preCnt == PRE_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (ctl.slotGo) begin
      preCnt  <= '0;
      tickCnt <= '0;
    end else if (tickEn) begin
      preCnt <= '0;
      if (tickCnt != '1) tickCnt <= tickCnt + CNT_W'(1);
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  // two-flop synchronizer plus edge history, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busMeta <= 1'b1;
      busSync <= 1'b1;
      busPrev <= 1'b1;
    end else begin
      busMeta <= owIn;
      busSync <= busMeta;
      busPrev <= busSync;
    end
  end
  assign riseSeen = busSync & ~busPrev;

  // phase times for the latched slot kind
  always_comb begin
    unique case ({odReg, rstReg})
      2'b00: begin
        relT = wbitReg ? CNT_W'(T_B1_LOW) : CNT_W'(T_B0_LOW);
        smpT = CNT_W'(T_B_SMP);
        endT = CNT_W'(T_B_END);
      end
      2'b01: begin
        relT = CNT_W'(T_RST_LOW);
        smpT = CNT_W'(T_RST_SMP);
        endT = CNT_W'(T_RST_END);
      end
      2'b10: begin
        relT = wbitReg ? CNT_W'(O_B1_LOW) : CNT_W'(O_B0_LOW);
        smpT = CNT_W'(O_B_SMP);
        endT = CNT_W'(O_B_END);
      end
      default: begin
        relT = CNT_W'(O_RST_LOW);
        smpT = CNT_W'(O_RST_SMP);
        endT = CNT_W'(O_RST_END);
      end
    endcase
    wdT = endT + CNT_W'(WDOG_EXTRA);
  end

  // slot drive and release-edge capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstReg   <= 1'b0;
      odReg    <= 1'b0;
      wbitReg  <= 1'b1;
      driveLow <= 1'b0;
      edgeSeen <= 1'b0;
      capTick  <= '0;
    end else if (ctl.slotGo) begin
      rstReg   <= ctl.slotRst;
      odReg    <= ctl.slotOd;
      wbitReg  <= ctl.slotRst ? 1'b1 : (ctl.slotUseTx ? txBuf[0] : ctl.slotWbit);
      driveLow <= 1'b1;
      edgeSeen <= 1'b0;
      capTick  <= '0;
    end else begin
      if (driveLow && (tickCnt >= relT)) driveLow <= 1'b0;
      if (!driveLow && !edgeSeen && riseSeen) begin
        edgeSeen <= 1'b1;
        capTick  <= tickCnt;
      end
    end
  end

  assign owDriveLow      = driveLow;
  assign sts.slotDone    = edgeSeen && (tickCnt >= endT);
  assign sts.slotTimeout = !edgeSeen && (tickCnt >= wdT);
  assign sts.bitVal      = !(capTick > smpT);

  // block shifter, bit i of the block in slot i
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf  <= '0;
      rxBuf  <= '0;
      bitIdx <= '0;
    end else if (ctl.blkLoad) begin
      txBuf  <= ctl.blkRdMode ? '1 : blkWrData;
      rxBuf  <= '0;
      bitIdx <= '0;
    end else if (ctl.blkShift) begin
      rxBuf[bitIdx] <= sts.bitVal;
      txBuf         <= txBuf >> 1;
      bitIdx        <= bitIdx + IDX_W'(1);
    end
  end

  assign blkRdData = rxBuf;

endmodule

// File: rtl/ow_control.sv
module ow_control
  import ow_pkg::*;
#(
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cmdReset,
  input  logic             wrBit,
  input  logic             overdrive,
  input  logic             blkStart,
  input  logic             blkRead,
  input  logic [LEN_W-1:0] blkLen,
  input  owStatus_t        sts,
  output owStrobe_t        ctl,
  output logic             busy,
  output logic             done,
  output logic             result,
  output owErr_e           err
);

  owState_e         state, nxt;
  logic             blkMode;
  logic             isRst;
  logic             odReg;
  logic [LEN_W-1:0] bitsLeft;

  always_comb begin
    ctl = '0;
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.slotGo   = 1'b1;
          ctl.slotRst  = cmdReset;
          ctl.slotWbit = wrBit;
          ctl.slotOd   = overdrive;
          nxt          = ST_RUN;
        end else if (blkStart) begin
          ctl.blkLoad   = 1'b1;
          ctl.blkRdMode = blkRead;
          nxt           = ST_NEXT;
        end
      end
      ST_RUN: begin
        if (sts.slotTimeout) begin
          nxt = ST_IDLE;
        end else if (sts.slotDone) begin
          if (blkMode) begin
            ctl.blkShift = 1'b1;
            nxt          = ST_NEXT;
          end else begin
            nxt = ST_IDLE;
          end
        end
      end
      ST_NEXT: begin
        if (bitsLeft == '0) begin
          nxt = ST_IDLE;
        end else begin
          ctl.slotGo    = 1'b1;
          ctl.slotUseTx = 1'b1;
          ctl.slotOd    = odReg;
          nxt           = ST_RUN;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      blkMode  <= 1'b0;
      isRst    <= 1'b0;
      odReg    <= 1'b0;
      bitsLeft <= '0;
      done     <= 1'b0;
      result   <= 1'b0;
      err      <= ERR_NONE;
    end else begin
      state <= nxt;
      done  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            blkMode <= 1'b0;
            isRst   <= cmdReset;
          end else if (blkStart) begin
            blkMode  <= 1'b1;
            isRst    <= 1'b0;
            odReg    <= overdrive;
            bitsLeft <= blkLen;
          end
        end
        ST_RUN: begin
          if (sts.slotTimeout) begin
            done   <= 1'b1;
            result <= 1'b0;
            if (blkMode)    err <= ERR_HW;
            else if (isRst) err <= ERR_PRESENCE;
            else            err <= ERR_DATA;
          end else if (sts.slotDone) begin
            if (blkMode) begin
              bitsLeft <= bitsLeft - LEN_W'(1);
            end else begin
              done   <= 1'b1;
              result <= sts.bitVal;
              err    <= ERR_NONE;
            end
          end
        end
        ST_NEXT: begin
          if (bitsLeft == '0) begin
            done   <= 1'b1;
            result <= 1'b0;
            err    <= ERR_NONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine
  import ow_pkg::*;
#(
  parameter int TICK_DIV   = 100,
  parameter int CNT_W      = 12,
  parameter int MAX_BITS   = 64,
  parameter int T_RST_LOW  = 960,
  parameter int T_RST_SMP  = 1100,
  parameter int T_RST_END  = 1920,
  parameter int T_B1_LOW   = 12,
  parameter int T_B0_LOW   = 120,
  parameter int T_B_SMP    = 30,
  parameter int T_B_END    = 140,
  parameter int O_RST_LOW  = 140,
  parameter int O_RST_SMP  = 157,
  parameter int O_RST_END  = 280,
  parameter int O_B1_LOW   = 2,
  parameter int O_B0_LOW   = 15,
  parameter int O_B_SMP    = 4,
  parameter int O_B_END    = 20,
  parameter int WDOG_EXTRA = 64,
  localparam int LEN_W     = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                cmdReset,
  input  logic                wrBit,
  input  logic                overdrive,
  input  logic                blkStart,
  input  logic                blkRead,
  input  logic [LEN_W-1:0]    blkLen,
  input  logic [MAX_BITS-1:0] blkWrData,
  output logic                busy,
  output logic                done,
  output logic                result,
  output logic [1:0]          err,
  output logic [MAX_BITS-1:0] blkRdData,
  output logic                owDriveLow,
  input  logic                owIn
);

  owStrobe_t ctl;
  owStatus_t sts;
  owErr_e    errE;

  ow_control #(.LEN_W(LEN_W)) i_ctrl (
    .clk(clk), .rstN(rstN),
    .start(start), .cmdReset(cmdReset), .wrBit(wrBit), .overdrive(overdrive),
    .blkStart(blkStart), .blkRead(blkRead), .blkLen(blkLen),
    .sts(sts), .ctl(ctl),
    .busy(busy), .done(done), .result(result), .err(errE)
  );

  ow_datapath #(
    .TICK_DIV(TICK_DIV), .CNT_W(CNT_W), .MAX_BITS(MAX_BITS),
    .T_RST_LOW(T_RST_LOW), .T_RST_SMP(T_RST_SMP), .T_RST_END(T_RST_END),
    .T_B1_LOW(T_B1_LOW), .T_B0_LOW(T_B0_LOW), .T_B_SMP(T_B_SMP), .T_B_END(T_B_END),
    .O_RST_LOW(O_RST_LOW), .O_RST_SMP(O_RST_SMP), .O_RST_END(O_RST_END),
    .O_B1_LOW(O_B1_LOW), .O_B0_LOW(O_B0_LOW), .O_B_SMP(O_B_SMP), .O_B_END(O_B_END),
    .WDOG_EXTRA(WDOG_EXTRA)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .owIn(owIn), .owDriveLow(owDriveLow),
    .blkWrData(blkWrData), .blkRdData(blkRdData),
    .sts(sts)
  );

  assign err = errE;

endmodule

// File: rtl/ow_slot_engine_chk.sv
module ow_slot_engine_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       result,
  input logic [1:0] err,
  input logic       owDriveLow
);

  // R1: line released whenever no command runs
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !owDriveLow);

  // R2: start while idle makes the engine busy on the next edge
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R2: done lasts one cycle
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: busy only falls together with done
  assert_busy_fall_done_R2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R3: the line is only pulled low inside a command
  assert_drive_in_cmd_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(owDriveLow) |-> busy);

  // R8 / R11: an error ending reports result 0
  assert_err_result_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && (err != 2'd0)) |-> !result);

endmodule

bind ow_slot_engine ow_slot_engine_chk i_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .result(result), .err(err), .owDriveLow(owDriveLow)
);

// File: tb/test_ow_slot_engine.sv
`timescale 1ns/1ps
module test_ow_slot_engine;

  localparam int DIV = 4;
  localparam int MB  = 64;
  localparam int RL = 20, RS = 30, RE = 40;
  localparam int B1 = 2,  B0 = 10, BS = 5, BE = 14;
  localparam int ORL = 8, ORS = 12, ORE = 16;
  localparam int OB1 = 1, OB0 = 4, OBS = 3, OBE = 8;
  localparam int WD = 8;
  localparam int LW = $clog2(MB + 1);

  logic clk = 0, rstN = 0;
  logic start = 0, cmdReset = 0, wrBit = 0, overdrive = 0;
  logic blkStart = 0, blkRead = 0;
  logic [LW-1:0] blkLen = '0;
  logic [MB-1:0] blkWrData = '0;
  logic busy, done, result, owDriveLow, owIn;
  logic [1:0] err;
  logic [MB-1:0] blkRdData;

  always #2.5 clk = ~clk;

  ow_slot_engine #(
    .TICK_DIV(DIV), .CNT_W(8), .MAX_BITS(MB),
    .T_RST_LOW(RL), .T_RST_SMP(RS), .T_RST_END(RE),
    .T_B1_LOW(B1), .T_B0_LOW(B0), .T_B_SMP(BS), .T_B_END(BE),
    .O_RST_LOW(ORL), .O_RST_SMP(ORS), .O_RST_END(ORE),
    .O_B1_LOW(OB1), .O_B0_LOW(OB0), .O_B_SMP(OBS), .O_B_END(OBE),
    .WDOG_EXTRA(WD)
  ) i_ow_slot_engine (
    .clk(clk), .rstN(rstN), .start(start), .cmdReset(cmdReset), .wrBit(wrBit),
    .overdrive(overdrive), .blkStart(blkStart), .blkRead(blkRead), .blkLen(blkLen),
    .blkWrData(blkWrData), .busy(busy), .done(done), .result(result), .err(err),
    .blkRdData(blkRdData), .owDriveLow(owDriveLow), .owIn(owIn)
  );

  // device model: holds the line for devHold clocks after each master low start
  int devHold = 0, devCnt = 0, devIdx = 0;
  logic devStuck = 0, devPatMode = 0, prevDrive = 0;
  logic [MB-1:0] devPat = '0;

  always @(posedge clk) begin
    prevDrive <= owDriveLow;
    if (owDriveLow && !prevDrive) begin
      if (devPatMode) begin
        devCnt <= devPat[devIdx] ? 0 : devHold;
        devIdx <= devIdx + 1;
      end else begin
        devCnt <= devHold;
      end
    end else if (devCnt > 0) begin
      devCnt <= devCnt - 1;
    end
  end
  assign owIn = !(owDriveLow || (devCnt > 0) || devStuck);

  // low pulse length log
  int lens [0:255];
  int nSlots = 0, curLen = 0;
  always @(negedge clk) begin
    if (owDriveLow) curLen <= curLen + 1;
    else if (curLen > 0) begin
      lens[nSlots] <= curLen;
      nSlots <= nSlots + 1;
      curLen <= 0;
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int holdFor(input int smp, input int en);
    return ((smp + en) / 2) * DIV;
  endfunction

  task automatic waitDone(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      start = 0;
      blkStart = 0;
    end while (!done && cyc < 20000);
  endtask

  task automatic runSlot(input logic rst, input logic wb, input logic od, output int cyc);
    @(negedge clk);
    cmdReset = rst; wrBit = wb; overdrive = od; start = 1;
    waitDone(cyc);
  endtask

  task automatic t_reset_state();
    chk("R1", "drive low after reset", owDriveLow, 0);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "done after reset", done, 0);
    chk("R1", "rx data after reset", blkRdData, 0);
  endtask

  task automatic t_bit_slots();
    int cyc, n;
    devHold = 0;
    n = nSlots;
    runSlot(0, 1, 0, cyc);
    chk("R5", "write1 reads 1", result, 1);
    chk("R12", "write1 err", err, 0);
    chk("R3", "write1 low length", lens[n], B1 * DIV + 1);
    chk("R7", "bit slot done timing", cyc, BE * DIV + 2);
    chk("R2", "busy low at done", busy, 0);
    @(negedge clk);
    chk("R2", "done one cycle", done, 0);
    n = nSlots;
    runSlot(0, 0, 0, cyc);
    chk("R5", "write0 reads 0", result, 0);
    chk("R3", "write0 low length", lens[n], B0 * DIV + 1);
    devHold = holdFor(BS, BE);
    runSlot(0, 1, 0, cyc);
    chk("R5", "device holds past sample", result, 0);
    chk("R7", "late edge done timing", cyc, BE * DIV + 2);
    devHold = 0;
  endtask

  task automatic t_reset_slots();
    int cyc, n;
    devHold = holdFor(RS, RE);
    n = nSlots;
    runSlot(1, 0, 0, cyc);
    chk("R6", "presence with wrBit 0", result, 0);
    chk("R3", "reset low length", lens[n], RL * DIV + 1);
    chk("R7", "reset done timing", cyc, RE * DIV + 2);
    runSlot(1, 1, 0, cyc);
    chk("R6", "presence with wrBit 1", result, 0);
    devHold = 0;
    runSlot(1, 0, 0, cyc);
    chk("R6", "no device", result, 1);
    chk("R12", "reset err", err, 0);
  endtask

  task automatic t_overdrive();
    int cyc, n;
    devHold = 0;
    n = nSlots;
    runSlot(0, 1, 1, cyc);
    chk("R4", "od write1 result", result, 1);
    chk("R4", "od write1 length", lens[n], OB1 * DIV + 1);
    chk("R4", "od bit done timing", cyc, OBE * DIV + 2);
    n = nSlots;
    runSlot(0, 0, 1, cyc);
    chk("R4", "od write0 result", result, 0);
    chk("R4", "od write0 length", lens[n], OB0 * DIV + 1);
    devHold = holdFor(OBS, OBE);
    runSlot(0, 1, 1, cyc);
    chk("R4", "od read0 result", result, 0);
    devHold = holdFor(ORS, ORE);
    n = nSlots;
    runSlot(1, 1, 1, cyc);
    chk("R4", "od presence result", result, 0);
    chk("R4", "od reset length", lens[n], ORL * DIV + 1);
    chk("R4", "od reset timing", cyc, ORE * DIV + 2);
    devHold = 0;
    runSlot(1, 1, 1, cyc);
    chk("R4", "od no device", result, 1);
  endtask

  task automatic t_watchdog();
    int cyc;
    devStuck = 1;
    runSlot(1, 1, 0, cyc);
    chk("R8", "reset timeout err", err, 1);
    chk("R8", "reset timeout result", result, 0);
    chk("R8", "reset timeout timing", cyc, (RE + WD) * DIV + 2);
    runSlot(0, 1, 0, cyc);
    chk("R8", "bit timeout err", err, 2);
    chk("R8", "bit timeout timing", cyc, (BE + WD) * DIV + 2);
    devStuck = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_busy_ignore();
    int cyc, n;
    devHold = 0;
    n = nSlots;
    @(negedge clk);
    cmdReset = 0; wrBit = 1; overdrive = 0; start = 1;
    @(negedge clk);
    start = 0;
    @(negedge clk);
    cmdReset = 1; wrBit = 0; start = 1; blkStart = 1; blkLen = 3;
    waitDone(cyc);
    chk("R2", "ignored strobes: timing", cyc + 2, BE * DIV + 2);
    chk("R2", "ignored strobes: result", result, 1);
    chk("R2", "ignored strobes: length", lens[n], B1 * DIV + 1);
    repeat (3) @(negedge clk);
    chk("R2", "ignored strobes: no extra slot", nSlots, n + 1);
  endtask

  task automatic t_both_strobes();
    int cyc, n;
    devHold = 0;
    n = nSlots;
    @(negedge clk);
    cmdReset = 0; wrBit = 0; overdrive = 0; start = 1;
    blkStart = 1; blkRead = 1; blkLen = 5;
    waitDone(cyc);
    chk("R2", "start wins: timing", cyc, BE * DIV + 2);
    chk("R2", "start wins: length", lens[n], B0 * DIV + 1);
    repeat (3) @(negedge clk);
    chk("R2", "start wins: one slot", nSlots, n + 1);
  endtask

  task automatic t_block_write();
    int cyc, n;
    logic [7:0] sent;
    devHold = 0;
    n = nSlots;
    @(negedge clk);
    blkWrData = 64'hA5; blkRead = 0; blkLen = 8; overdrive = 0; blkStart = 1;
    waitDone(cyc);
    chk("R9", "block write slot count", nSlots - n, 8);
    for (int i = 0; i < 8; i++) sent[i] = (lens[n + i] == B1 * DIV + 1);
    chk("R9", "block write bits lsb first", sent, 8'hA5);
    chk("R10", "block write readback", blkRdData, 64'hA5);
    chk("R12", "block write err", err, 0);
  endtask

  task automatic t_block_read();
    int cyc, n;
    logic allShort;
    devHold = holdFor(BS, BE);
    devPatMode = 1; devIdx = 0; devPat = 64'h5C3;
    n = nSlots;
    @(negedge clk);
    blkRead = 1; blkWrData = 64'h0; blkLen = 12; overdrive = 0; blkStart = 1;
    waitDone(cyc);
    chk("R10", "block read 12 bits", blkRdData, 64'h5C3);
    allShort = 1;
    for (int i = 0; i < 12; i++) if (lens[n + i] != B1 * DIV + 1) allShort = 0;
    chk("R10", "block read sends ones", allShort, 1);
    devIdx = 0; devPat = 64'h0D;
    @(negedge clk);
    blkLen = 5; blkStart = 1;
    waitDone(cyc);
    chk("R10", "buffer cleared, 5 bits", blkRdData, 64'h0D);
    chk("R12", "block read err", err, 0);
    chk("R12", "block read result", result, 0);
    devPatMode = 0; devHold = 0;
  endtask

  task automatic t_block_abort();
    int cyc, n;
    devStuck = 1;
    n = nSlots;
    @(negedge clk);
    blkRead = 0; blkWrData = 64'hFF; blkLen = 6; blkStart = 1;
    waitDone(cyc);
    chk("R11", "block abort err", err, 3);
    chk("R11", "block abort result", result, 0);
    devStuck = 0;
    repeat (6) @(negedge clk);
    chk("R11", "block abort one slot", nSlots - n, 1);
  endtask

  task automatic t_block_empty();
    int cyc, n;
    n = nSlots;
    @(negedge clk);
    blkLen = 0; blkStart = 1;
    waitDone(cyc);
    chk("R12", "empty block timing", cyc, 2);
    chk("R12", "empty block err", err, 0);
    repeat (3) @(negedge clk);
    chk("R12", "empty block no slot", nSlots, n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    t_reset_state();
    t_bit_slots();
    t_reset_slots();
    t_overdrive();
    t_watchdog();
    t_busy_ignore();
    t_both_strobes();
    t_block_write();
    t_block_read();
    t_block_abort();
    t_block_empty();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule